// File: doc/BRIEF.md
# Event Timer with Shared Prescaler

This block holds an 8-bit count register that software can load and read back at any time. The register advances on one of two kinds of ticks. In timer mode it takes an internal instruction tick, which fires once every `CYC_DIV` system clocks. In counter mode it takes an event from outside the block. That event comes either from an input pin, where the active edge can be chosen, or from the digital output of an on-chip comparator. External levels pass through a two-stage synchronizer and an edge detector before they reach the counter.

An 8-bit prescaler divides the tick stream further. It serves one of two consumers, chosen by an assignment bit: the count register, or the watchdog path. When the count register does not use the prescaler, it advances on every tick it receives, and the watchdog pulse goes through the prescaler instead. Software cannot see the prescaler's internal count. A load of the count register suspends counting for the next two ticks. When the count rolls over, the block raises a one-cycle flag.

Top module: `evt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0x00, `ovf` becomes 0 and `wdt_tick` becomes 0. The instruction divider, the synchronizer and the prescaler are also cleared.
- R2: When `wr_en` is 1 at an edge, `count` shows `wr_data` after that edge. A load takes priority over an increment in the same cycle.
- R3: With `ext_mode`=0, the tick source is the instruction tick. The instruction tick is high in every `CYC_DIV`-th cycle after reset, counting from cycle `CYC_DIV`-1. With `ps_to_wdt`=1, `count` advances by exactly 1 on each instruction tick.
- R4: With `ext_mode`=1 and `pin_sel`=1, the source is `pin_in`. With `fall_edge`=0, a low-to-high transition is counted. With `fall_edge`=1, a high-to-low transition is counted. A transition sampled at edge k reaches `count` at edge k+2.
- R5: With `ext_mode`=1 and `pin_sel`=0, the source is `cmp_in`, sampled through the same edge select and synchronizer as the pin, and `pin_in` has no effect on `count`.
- R6: After a load, the next two ticks that reach the counter are discarded. Counting resumes from the loaded value on the third tick.
- R7: With `ps_to_wdt`=0, a tick reaches the counter once for every 2^(`ps_rate`+1) source ticks (1:2 up to 1:256). The prescaler passes on the source tick on which its internal count before increment has all of its low `ps_rate`+1 bits set.
- R8: A load while `ps_to_wdt`=0 clears the prescaler count. `ps_rate` is unchanged.
- R9: With `ps_to_wdt`=1, the prescaler divides `wdt_in` pulses by 2^`ps_rate` (1:1 up to 1:128), and `wdt_tick` shows each passed pulse one cycle after it arrives.
- R10: With `ps_to_wdt`=0, `wdt_tick` repeats `wdt_in` delayed by one cycle, without any division.
- R11: An increment from 0xFF yields 0x00, and `ovf` is 1 for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | 0: instruction tick, 1: external event |
| pin_sel | input | 1 | External source: 1 pin, 0 comparator |
| fall_edge | input | 1 | 0: rising edges count, 1: falling edges |
| ps_to_wdt | input | 1 | 0: prescaler serves the counter, 1: the watchdog path |
| ps_rate | input | 3 | Prescale rate code |
| pin_in | input | 1 | Asynchronous event pin |
| cmp_in | input | 1 | Asynchronous comparator output |
| wdt_in | input | 1 | One-cycle watchdog base pulse |
| wr_en | input | 1 | Load strobe for the count register |
| wr_data | input | 8 | Load value |
| count | output | 8 | Count register value |
| ovf | output | 1 | One-cycle rollover flag |
| wdt_tick | output | 1 | Watchdog-path pulse |

## Verification
The assertions treat `wdt_in` and the load strobe as plain synchronous inputs. They rely on the configuration bits only through the signals that those bits have already selected, so a configuration change at any cycle breaks none of them. The asynchronous pins are also allowed to change at any cycle, because each assertion checks the synchronized edge pulse and not the raw pin level. The stimulus changes every input just after a falling clock edge. It covers directed phases for each mode and rate, followed by a long run with random selections, loads and pin activity.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic {
    SRC_CMP = 1'b0,
    SRC_PIN = 1'b1
  } ext_src_e;

  // mask of the low 'shift' bits of a W-bit prescaler count
  function automatic logic [7:0] low_mask8(input logic [3:0] shift);
    low_mask8 = ~(8'hFF << shift);
  endfunction

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_sel,
  input  logic fall_edge,
  input  logic pin_in,
  input  logic cmp_in,
  output logic evt
);
  import evt_timer_pkg::*;

  logic          raw;
  logic [STAGES:0] sh_q;

  always_comb begin
    raw = (ext_src_e'(pin_sel) == SRC_PIN) ? pin_in : cmp_in;
    raw = raw ^ fall_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], raw};
  end

  assign evt = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4: a synchronized edge yields a single-cycle pulse
  a_r4_evt_single: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);

endmodule

// File: rtl/evt_timer_prescaler.sv
module evt_timer_prescaler #(
  parameter int PS_W   = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              to_wdt,
  input  logic [RATE_W-1:0] rate,
  input  logic              evt_in,
  input  logic              clr,
  output logic              evt_out
);
  import evt_timer_pkg::*;

  localparam int SH_W = RATE_W + 1;

  logic [PS_W-1:0] pre_q;
  logic [SH_W-1:0] shift;
  logic [PS_W-1:0] mask;

  always_comb begin
    shift = to_wdt ? {1'b0, rate} : ({1'b0, rate} + SH_W'(1));
    mask  = PS_W'(low_mask8(4'(shift)));
  end

  assign evt_out = evt_in && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre_q <= '0;
    else if (evt_in) pre_q <= pre_q + PS_W'(1);
  end

  // R8: a clear leaves the prescaler at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0));

  // R7: the count only moves on an incoming tick
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!evt_in && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W   = 8,
  parameter int INHIBIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam int IH_W = $clog2(INHIBIT + 1);

  logic [IH_W-1:0] inhib_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      inhib_q <= '0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_en) begin
        cnt_q   <= wr_data;
        inhib_q <= IH_W'(INHIBIT);
      end else if (inc) begin
        if (inhib_q != '0) begin
          inhib_q <= inhib_q - IH_W'(1);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          ovf_q <= (cnt_q == {CNT_W{1'b1}});
        end
      end
    end
  end

  // R2: a load shows its value after the edge
  a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wr_data)));

  // R6: an inhibited tick leaves the count alone
  a_r6_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_en && inhib_q != '0) |=> $stable(cnt_q));

  // R3: without a load the count steps by at most one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R11: the rollover flag coincides with a zero count
  a_r11_ovf_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0));

endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W   = 8,
  parameter int PS_W    = 8,
  parameter int RATE_W  = 3,
  parameter int CYC_DIV = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              pin_sel,
  input  logic              fall_edge,
  input  logic              ps_to_wdt,
  input  logic [RATE_W-1:0] ps_rate,
  input  logic              pin_in,
  input  logic              cmp_in,
  input  logic              wdt_in,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic              wdt_tick
);
  localparam int CYC_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;

  logic [CYC_W-1:0] cyc_q;
  logic             icyc;
  logic             ext_evt;
  logic             src_evt;
  logic             ps_in;
  logic             ps_out;
  logic             cnt_inc;
  logic             wdt_q;

  always_ff @(posedge clk) begin
    if (rst)                              cyc_q <= '0;
    else if (cyc_q == CYC_W'(CYC_DIV - 1)) cyc_q <= '0;
    else                                  cyc_q <= cyc_q + CYC_W'(1);
  end
  assign icyc = (cyc_q == CYC_W'(CYC_DIV - 1));

  evt_timer_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_sel(pin_sel), .fall_edge(fall_edge),
    .pin_in(pin_in), .cmp_in(cmp_in), .evt(ext_evt)
  );

  assign src_evt = ext_mode ? ext_evt : icyc;
  assign ps_in   = ps_to_wdt ? wdt_in : src_evt;

  evt_timer_prescaler #(.PS_W(PS_W), .RATE_W(RATE_W)) u_ps (
    .clk(clk), .rst(rst), .to_wdt(ps_to_wdt), .rate(ps_rate),
    .evt_in(ps_in), .clr(wr_en && !ps_to_wdt), .evt_out(ps_out)
  );

  assign cnt_inc = ps_to_wdt ? src_evt : ps_out;

  evt_timer_core #(.CNT_W(CNT_W), .INHIBIT(2)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .inc(cnt_inc), .cnt_q(count), .ovf_q(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_q <= 1'b0;
    else     wdt_q <= ps_to_wdt ? ps_out : wdt_in;
  end
  assign wdt_tick = wdt_q;

  // R10: unassigned watchdog path repeats its input one cycle late
  a_r10_wdt_pass: assert property (@(posedge clk) disable iff (rst)
    (!ps_to_wdt) |=> (wdt_tick == $past(wdt_in)));

  // R9: a watchdog tick needs a base pulse in the previous cycle
  a_r9_wdt_needs_base: assert property (@(posedge clk) disable iff (rst)
    (!wdt_in) |=> !wdt_tick);

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_mode = 0, pin_sel = 1, fall_edge = 0, ps_to_wdt = 1;
  logic [2:0] ps_rate = 0;
  logic pin_in = 0, cmp_in = 0, wdt_in = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count;
  logic ovf, wdt_tick;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int m_cyc, m_s1, m_s2, m_s3, m_pre, m_cnt, m_inh, m_ovf, m_wdt;

  always #(CLK_P/2) clk = ~clk;

  evt_timer u_dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .pin_sel(pin_sel),
    .fall_edge(fall_edge), .ps_to_wdt(ps_to_wdt), .ps_rate(ps_rate),
    .pin_in(pin_in), .cmp_in(cmp_in), .wdt_in(wdt_in), .wr_en(wr_en),
    .wr_data(wr_data), .count(count), .ovf(ovf), .wdt_tick(wdt_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    int raw, evt, tick, src, pev, ratio, pout, inc;
    if (rst) begin
      m_cyc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
      m_cnt = 0; m_inh = 0; m_ovf = 0; m_wdt = 0;
      return;
    end
    tick  = (m_cyc == DIV-1);
    m_cyc = (m_cyc + 1) % DIV;
    raw   = (pin_sel ? pin_in : cmp_in) ^ fall_edge;
    evt   = m_s2 && !m_s3;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = raw;
    src   = ext_mode ? evt : tick;
    pev   = ps_to_wdt ? wdt_in : src;
    ratio = ps_to_wdt ? (1 << ps_rate) : (2 << ps_rate);
    pout  = pev && ((m_pre % ratio) == ratio - 1);
    if (wr_en && !ps_to_wdt) m_pre = 0;
    else if (pev)            m_pre = (m_pre + 1) % 256;
    inc   = ps_to_wdt ? src : pout;
    m_ovf = 0;
    if (wr_en) begin
      m_cnt = wr_data; m_inh = 2;
    end else if (inc) begin
      if (m_inh > 0) m_inh--;
      else begin
        if (m_cnt == 255) m_ovf = 1;
        m_cnt = (m_cnt + 1) % 256;
      end
    end
    m_wdt = ps_to_wdt ? pout : wdt_in;
  endtask

  always @(posedge clk) begin
    cyc++;
    model_step();
    #(CLK_P/4);
    if (!done) begin
      check({cur_req, " count"}, count, m_cnt);
      check({cur_req, " ovf"}, ovf, m_ovf);
      check({cur_req, " wdt_tick"}, wdt_tick, m_wdt);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input int v);
    @(negedge clk); wr_en = 1; wr_data = 8'(v);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pin_pulses(input int n, input bit use_cmp);
    for (int i = 0; i < n; i++) begin
      if (use_cmp) cmp_in = ~cmp_in; else pin_in = ~pin_in;
      clocks(3);
      if (use_cmp) cmp_in = ~cmp_in; else pin_in = ~pin_in;
      clocks(3);
    end
  endtask

  initial begin
    clocks(3);
    cur_req = "R1";
    check("R1 count", count, 0);
    check("R1 ovf", ovf, 0);
    check("R1 wdt_tick", wdt_tick, 0);
    rst = 0;

    // R3 timer mode, unprescaled
    cur_req = "R3";
    load(0);
    clocks(60);

    // R2 / R6 load then held for two instruction ticks
    cur_req = "R2";
    load(8'h5A);
    check("R2 loaded", count, 8'h5A);
    clocks(5);
    cur_req = "R6";
    check("R6 held", count, 8'h5A);
    clocks(20);

    // R11 rollover
    cur_req = "R11";
    load(8'hFD);
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ovf) begin seen++; check("R11 count at ovf", count, 0); end
      end
      check("R11 one pulse", seen, 1);
    end

    // R4 rising pin edges
    cur_req = "R4";
    ext_mode = 1; pin_sel = 1; fall_edge = 0; pin_in = 0;
    clocks(6);
    load(0);
    pin_pulses(5, 0);
    check("R4 rising count", count, 3);
    fall_edge = 1;
    clocks(6);
    load(0);
    pin_pulses(4, 0);
    check("R4 falling count", count, 2);

    // R5 comparator source, pin ignored
    cur_req = "R5";
    fall_edge = 0; pin_sel = 0; cmp_in = 0; pin_in = 0;
    clocks(6);
    load(10);
    pin_pulses(4, 0);
    check("R5 pin ignored", count, 10);
    pin_pulses(4, 1);
    check("R5 cmp count", count, 12);

    // R7 / R8 prescaled timer, all rates
    ext_mode = 0; ps_to_wdt = 0;
    for (int r = 0; r < 8; r++) begin
      cur_req = "R7";
      ps_rate = 3'(r);
      load(0);
      clocks(40 + 16 * r);
      cur_req = "R8";
      load(8'h20);
      clocks(20);
    end

    // R9 / R10 watchdog path
    for (int a = 0; a < 2; a++) begin
      ps_to_wdt = 1'(a);
      for (int r = 0; r < 8; r += 3) begin
        cur_req = a ? "R9" : "R10";
        ps_rate = 3'(r);
        for (int k = 0; k < 40; k++) begin
          @(negedge clk); wdt_in = (k % 3 == 0);
        end
      end
    end
    wdt_in = 0;

    // mixed random run
    cur_req = "R2";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (k % 200 == 0) begin
        ext_mode = 1'($urandom); pin_sel = 1'($urandom);
        fall_edge = 1'($urandom); ps_to_wdt = 1'($urandom);
        ps_rate = 3'($urandom);
      end
      pin_in  = ($urandom % 4 == 0) ? ~pin_in : pin_in;
      cmp_in  = ($urandom % 5 == 0) ? ~cmp_in : cmp_in;
      wdt_in  = ($urandom % 3 == 0);
      wr_en   = ($urandom % 97 == 0);
      wr_data = 8'($urandom);
    end
    wr_en = 0;
    clocks(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule